// File: doc/BRIEF.md
# Interval Performance State Quantizer

This block watches a processor core over fixed control intervals and condenses each interval into a small state word for a voltage and frequency policy. It counts four kinds of single-cycle event strobes: retired instructions, core clock cycles (every cycle is one), accesses to the L2 cache and accesses to main memory. An interval ends once a programmed number of instructions has retired. At that point the block forms three per-instruction ratios (cycles, L2 accesses and memory accesses, each per instruction) and places each one into a bin using its own table of thresholds.

The thresholds need not be evenly spaced, so bins can be narrow where samples are dense. They are written through a small register port, one entry per write. No divider is used: an event count is compared against each threshold multiplied by the instruction count. The state word also carries the CPU and cache frequency indices that are in effect when the interval closes. It is presented with a one-cycle valid pulse and held until the next interval closes.

Top module: `perf_state_quantizer`

## Requirements
- R1: While `rst` is high, and in the cycle after reset, `state_valid` is 0 and `state_word` is 0.
- R2: The cycle in which the retired-instruction count of the current interval equals `INTERVAL_LEN` is the closing cycle. `state_valid` is 1 for exactly the one cycle that follows it.
- R3: Events whose strobes are high in the closing cycle belong to the new interval. The closing cycle is also counted as the new interval's first core cycle.
- R4: The CPU bin field `state_word[12:9]` (11 bins, 0 to 10) equals the number of the 10 cycle thresholds T for which cycles×256 > T×instructions. Thresholds use 8 fractional bits.
- R5: The L2 bin field `state_word[8:6]` (8 bins) equals the number of the 7 L2 thresholds T for which L2 accesses×256 > T×instructions.
- R6: The memory bin field `state_word[5:4]` (4 bins) equals the number of the 3 memory thresholds T for which memory accesses×256 > T×instructions.
- R7: A ratio exactly equal to a threshold does not exceed it. Each bin includes its upper bound and excludes its lower bound.
- R8: `state_word[3:2]` and `state_word[1:0]` hold `cpu_freq_idx` and `l2_freq_idx`, sampled in the closing cycle. Each index selects one of four levels: 0 is 250 MHz and 3 is 1 GHz, in 250 MHz steps.
- R9: The cycle, L2 and memory counters saturate at 2^CNT_W−1 instead of wrapping. A stalled interval therefore reports the highest bin and not a small ratio.
- R10: A write with `thr_we`=1 stores `thr_wdata` into entry `thr_idx` of the table selected by `thr_feat` (0 = cycles, 1 = L2, 2 = memory). The new value applies to intervals that close after the write cycle. Out of reset, entry k of each table holds (k+1)×64.
- R11: Between valid pulses, `state_word` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_ret | input | 1 | One instruction retired this cycle |
| l2_acc | input | 1 | One L2 cache access this cycle |
| mem_acc | input | 1 | One main-memory access this cycle |
| cpu_freq_idx | input | 2 | Current CPU frequency level |
| l2_freq_idx | input | 2 | Current cache frequency level |
| thr_we | input | 1 | Threshold write enable |
| thr_feat | input | 2 | Table select for the write |
| thr_idx | input | 4 | Entry index for the write |
| thr_wdata | input | 16 | Threshold value, 8 fractional bits |
| state_valid | output | 1 | One-cycle pulse when a new state word is ready |
| state_word | output | 13 | Bins and frequency indices of the last interval |

## Verification
A wrong internal count stays hidden until the interval closes. It then appears as a shifted bin in the state word, one cycle after the closing cycle. A boundary that is off by one cycle moves the valid pulse, and it also changes the cycle count, which shows up in the CPU bin. The tests place ratios exactly on thresholds, put strobes in the closing cycle, and stall long enough for a wrapping counter to land in a lower bin than a saturating one. Each of these faults is therefore seen at the first pulse after the faulty cycle.

// File: rtl/pq_pkg.sv
`timescale 1ns/1ps
package pq_pkg;
    localparam int THR_W     = 16;
    localparam int FRAC_W    = 8;
    localparam int IDX_W     = 4;
    localparam int FREQ_W    = 2;
    localparam int CPI_BINS  = 11;
    localparam int L2_BINS   = 8;
    localparam int MEM_BINS  = 4;
    localparam int CPI_NTHR  = CPI_BINS - 1;
    localparam int L2_NTHR   = L2_BINS - 1;
    localparam int MEM_NTHR  = MEM_BINS - 1;
    localparam int CPI_BW    = $clog2(CPI_BINS);
    localparam int L2_BW     = $clog2(L2_BINS);
    localparam int MEM_BW    = $clog2(MEM_BINS);

    typedef enum logic [1:0] {
        FEAT_CPI = 2'd0,
        FEAT_L2  = 2'd1,
        FEAT_MEM = 2'd2
    } feat_e;

    typedef struct packed {
        logic [CPI_BW-1:0] cpi_bin;
        logic [L2_BW-1:0]  l2_bin;
        logic [MEM_BW-1:0] mem_bin;
        logic [FREQ_W-1:0] cpu_f;
        logic [FREQ_W-1:0] l2_f;
    } pstate_t;

    localparam int STATE_W = $bits(pstate_t);

    function automatic logic [THR_W-1:0] reset_thr(input int k);
        return THR_W'((k + 1) * 64);
    endfunction
endpackage

// File: rtl/pq_counters.sv
`timescale 1ns/1ps
module pq_counters #(
    parameter int LEN = 500000,
    parameter int CW  = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inst_ev,
    input  logic          l2_ev,
    input  logic          mem_ev,
    output logic [CW-1:0] inst_cnt,
    output logic [CW-1:0] cyc_cnt,
    output logic [CW-1:0] l2_cnt,
    output logic [CW-1:0] mem_cnt,
    output logic          closing
);
    localparam logic [CW-1:0] LEN_C = CW'(LEN);

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] a, input logic b);
        return (b && (a != '1)) ? a + CW'(1) : a;
    endfunction

    assign closing = (inst_cnt == LEN_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            inst_cnt <= '0;
            cyc_cnt  <= '0;
            l2_cnt   <= '0;
            mem_cnt  <= '0;
        end else if (closing) begin
            inst_cnt <= CW'(inst_ev);
            cyc_cnt  <= CW'(1);
            l2_cnt   <= CW'(l2_ev);
            mem_cnt  <= CW'(mem_ev);
        end else begin
            inst_cnt <= inst_cnt + CW'(inst_ev);
            cyc_cnt  <= sat_inc(cyc_cnt, 1'b1);
            l2_cnt   <= sat_inc(l2_cnt, l2_ev);
            mem_cnt  <= sat_inc(mem_cnt, mem_ev);
        end
    end
endmodule

// File: rtl/pq_thr_table.sv
`timescale 1ns/1ps
module pq_thr_table #(
    parameter int          N   = 10,
    parameter int          W   = 16,
    parameter int          IW  = 4,
    parameter logic [1:0]  SEL = 2'd0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [1:0]     feat,
    input  logic [IW-1:0]  idx,
    input  logic [W-1:0]   wdata,
    output logic [N*W-1:0] thr_flat
);
    logic [W-1:0] entry [N];

    always_ff @(posedge clk) begin
        for (int k = 0; k < N; k++) begin
            if (rst)
                entry[k] <= W'(pq_pkg::reset_thr(k));
            else if (we && (feat == SEL) && (idx == IW'(k)))
                entry[k] <= wdata;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign thr_flat[g*W +: W] = entry[g];
    end
endmodule

// File: rtl/pq_binner.sv
`timescale 1ns/1ps
module pq_binner #(
    parameter int N    = 10,
    parameter int W    = 16,
    parameter int CW   = 32,
    parameter int FRAC = 8,
    parameter int BW   = 4
) (
    input  logic [N*W-1:0] thr_flat,
    input  logic [CW-1:0]  ev_cnt,
    input  logic [CW-1:0]  inst_cnt,
    output logic [BW-1:0]  bin
);
    localparam int PW = CW + W;

    logic [PW-1:0] scaled_ev;
    logic [N-1:0]  above;

    assign scaled_ev = PW'(ev_cnt) << FRAC;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign above[g] = scaled_ev > (PW'(thr_flat[g*W +: W]) * PW'(inst_cnt));
    end

    always_comb begin
        bin = '0;
        for (int k = 0; k < N; k++)
            bin = bin + BW'(above[k]);
    end
endmodule

// File: rtl/perf_state_quantizer.sv
`timescale 1ns/1ps
module perf_state_quantizer
    import pq_pkg::*;
#(
    parameter int INTERVAL_LEN = 500000,
    parameter int CNT_W        = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inst_ret,
    input  logic                 l2_acc,
    input  logic                 mem_acc,
    input  logic [FREQ_W-1:0]    cpu_freq_idx,
    input  logic [FREQ_W-1:0]    l2_freq_idx,
    input  logic                 thr_we,
    input  logic [1:0]           thr_feat,
    input  logic [IDX_W-1:0]     thr_idx,
    input  logic [THR_W-1:0]     thr_wdata,
    output logic                 state_valid,
    output logic [STATE_W-1:0]   state_word
);
    logic [CNT_W-1:0] inst_cnt, cyc_cnt, l2_cnt, mem_cnt;
    logic             closing;

    logic [CPI_NTHR*THR_W-1:0] cpi_thr;
    logic [L2_NTHR*THR_W-1:0]  l2_thr;
    logic [MEM_NTHR*THR_W-1:0] mem_thr;

    pstate_t next_st, cur_st;

    pq_counters #(.LEN(INTERVAL_LEN), .CW(CNT_W)) u_cnt (
        .clk(clk), .rst(rst),
        .inst_ev(inst_ret), .l2_ev(l2_acc), .mem_ev(mem_acc),
        .inst_cnt(inst_cnt), .cyc_cnt(cyc_cnt),
        .l2_cnt(l2_cnt), .mem_cnt(mem_cnt),
        .closing(closing)
    );

    pq_thr_table #(.N(CPI_NTHR), .W(THR_W), .IW(IDX_W), .SEL(FEAT_CPI)) u_tcpi (
        .clk(clk), .rst(rst), .we(thr_we), .feat(thr_feat),
        .idx(thr_idx), .wdata(thr_wdata), .thr_flat(cpi_thr)
    );
    pq_thr_table #(.N(L2_NTHR), .W(THR_W), .IW(IDX_W), .SEL(FEAT_L2)) u_tl2 (
        .clk(clk), .rst(rst), .we(thr_we), .feat(thr_feat),
        .idx(thr_idx), .wdata(thr_wdata), .thr_flat(l2_thr)
    );
    pq_thr_table #(.N(MEM_NTHR), .W(THR_W), .IW(IDX_W), .SEL(FEAT_MEM)) u_tmem (
        .clk(clk), .rst(rst), .we(thr_we), .feat(thr_feat),
        .idx(thr_idx), .wdata(thr_wdata), .thr_flat(mem_thr)
    );

    pq_binner #(.N(CPI_NTHR), .W(THR_W), .CW(CNT_W), .FRAC(FRAC_W), .BW(CPI_BW)) u_bcpi (
        .thr_flat(cpi_thr), .ev_cnt(cyc_cnt), .inst_cnt(inst_cnt), .bin(next_st.cpi_bin)
    );
    pq_binner #(.N(L2_NTHR), .W(THR_W), .CW(CNT_W), .FRAC(FRAC_W), .BW(L2_BW)) u_bl2 (
        .thr_flat(l2_thr), .ev_cnt(l2_cnt), .inst_cnt(inst_cnt), .bin(next_st.l2_bin)
    );
    pq_binner #(.N(MEM_NTHR), .W(THR_W), .CW(CNT_W), .FRAC(FRAC_W), .BW(MEM_BW)) u_bmem (
        .thr_flat(mem_thr), .ev_cnt(mem_cnt), .inst_cnt(inst_cnt), .bin(next_st.mem_bin)
    );

    assign next_st.cpu_f = cpu_freq_idx;
    assign next_st.l2_f  = l2_freq_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_valid <= 1'b0;
            cur_st      <= '0;
        end else begin
            state_valid <= closing;
            if (closing)
                cur_st <= next_st;
        end
    end

    assign state_word = cur_st;
endmodule

// File: rtl/pq_checker.sv
`timescale 1ns/1ps
module pq_checker
    import pq_pkg::*;
#(
    parameter int LEN = 500000,
    parameter int CW  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               state_valid,
    input logic [STATE_W-1:0] state_word,
    input logic [FREQ_W-1:0]  cpu_freq_idx,
    input logic [FREQ_W-1:0]  l2_freq_idx,
    input logic [CW-1:0]      cyc_cnt,
    input logic               closing
);
    pstate_t st;
    assign st = state_word;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!state_valid && state_word == '0));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        state_valid |=> !state_valid);

    // R2
    pulse_after_close_chk: assert property (@(posedge clk) disable iff (rst)
        state_valid |-> $past(closing));

    // R4
    cpi_range_chk: assert property (@(posedge clk) disable iff (rst)
        state_valid |-> (st.cpi_bin <= CPI_BW'(CPI_NTHR)));

    // R8
    freq_capture_chk: assert property (@(posedge clk) disable iff (rst)
        state_valid |-> (st.cpu_f == $past(cpu_freq_idx) && st.l2_f == $past(l2_freq_idx)));

    // R9
    cycle_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_cnt == '1 && !closing) |=> (cyc_cnt == '1));

    // R11
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !state_valid |-> $stable(state_word));
endmodule

bind perf_state_quantizer pq_checker #(.LEN(INTERVAL_LEN), .CW(CNT_W)) u_pq_chk (
    .clk(clk), .rst(rst), .state_valid(state_valid), .state_word(state_word),
    .cpu_freq_idx(cpu_freq_idx), .l2_freq_idx(l2_freq_idx),
    .cyc_cnt(cyc_cnt), .closing(closing)
);

// File: tb/sim_perf_state_quantizer.sv
`timescale 1ns/1ps
module sim_perf_state_quantizer;
    localparam int LEN  = 16;
    localparam int CW   = 10;
    localparam int SMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inst_ret = 1'b0, l2_acc = 1'b0, mem_acc = 1'b0;
    logic [1:0]  cpu_freq_idx = 2'd0, l2_freq_idx = 2'd0;
    logic        thr_we = 1'b0;
    logic [1:0]  thr_feat = 2'd0;
    logic [3:0]  thr_idx = 4'd0;
    logic [15:0] thr_wdata = 16'd0;
    logic        state_valid;
    logic [12:0] state_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int tc [10];
    int tl [7];
    int tm [3];
    int mi = 0, mc = 0, ml = 0, mm = 0;
    bit pend = 0;
    int e_cpi, e_l2, e_mem, e_cf, e_lf;
    logic [12:0] last_state = '0;

    always #2.5 clk = ~clk;

    perf_state_quantizer #(.INTERVAL_LEN(LEN), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .inst_ret(inst_ret), .l2_acc(l2_acc), .mem_acc(mem_acc),
        .cpu_freq_idx(cpu_freq_idx), .l2_freq_idx(l2_freq_idx),
        .thr_we(thr_we), .thr_feat(thr_feat), .thr_idx(thr_idx), .thr_wdata(thr_wdata),
        .state_valid(state_valid), .state_word(state_word)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > SMAX) ? SMAX : v;
    endfunction

    // bin = number of thresholds strictly exceeded (R4, R5, R6, R7)
    function automatic int bin_of(input int feat, input int cnt, input int n);
        int b = 0;
        int lim = (feat == 0) ? 10 : (feat == 1) ? 7 : 3;
        for (int k = 0; k < lim; k++) begin
            longint t = (feat == 0) ? tc[k] : (feat == 1) ? tl[k] : tm[k];
            if (longint'(cnt) * 256 > t * n) b++;
        end
        return b;
    endfunction

    // One clock cycle with the given strobes, model update and output check
    task automatic step(input bit i, input bit l, input bit m);
        inst_ret = i; l2_acc = l; mem_acc = m;
        if (mi == LEN) begin
            pend  = 1;
            e_cpi = bin_of(0, mc, mi);
            e_l2  = bin_of(1, ml, mi);
            e_mem = bin_of(2, mm, mi);
            e_cf  = cpu_freq_idx;
            e_lf  = l2_freq_idx;
            // R3: strobes in the closing cycle open the new interval
            mi = i; mc = 1; ml = l; mm = m;
        end else begin
            pend = 0;
            mi += i; mc = sat(mc + 1); ml = sat(ml + l); mm = sat(mm + m);
        end
        @(posedge clk);
        #1;
        chk("R2 valid", state_valid, pend);
        if (pend && state_valid) begin
            last_state = state_word;
            chk("R4/R11 cpi bin", state_word[12:9], e_cpi);
            chk("R5/R11 l2 bin", state_word[8:6], e_l2);
            chk("R6/R11 mem bin", state_word[5:4], e_mem);
            chk("R8 cpu freq", state_word[3:2], e_cf);
            chk("R8 l2 freq", state_word[1:0], e_lf);
        end
        inst_ret = 0; l2_acc = 0; mem_acc = 0;
    endtask

    // R10: table write through the register port
    task automatic write_thr(input int feat, input int idx, input int val);
        thr_we = 1; thr_feat = 2'(feat); thr_idx = 4'(idx); thr_wdata = 16'(val);
        step(0, 0, 0);
        thr_we = 0;
        if (feat == 0) tc[idx] = val;
        else if (feat == 1) tl[idx] = val;
        else if (feat == 2) tm[idx] = val;
    endtask

    // Run until the next cycle is a closing cycle
    task automatic align();
        while (mi != LEN) step(1, 0, 0);
    endtask

    task automatic t_reset();
        // R1
        chk("R1 valid in reset", state_valid, 0);
        chk("R1 state in reset", state_word, 0);
        rst = 0;
        step(0, 0, 0);
        chk("R1 state after reset", state_word, 0);
    endtask

    task automatic t_program();
        for (int k = 0; k < 10; k++) write_thr(0, k, (k + 1) * 128);
        for (int k = 0; k < 7; k++)  write_thr(1, k, (k + 1) * 16);
        write_thr(2, 0, 8);
        write_thr(2, 1, 32);
        write_thr(2, 2, 64);
    endtask

    task automatic t_steady();
        cpu_freq_idx = 2'd3; l2_freq_idx = 2'd1;
        for (int c = 0; c < 60; c++) step(1, c % 4 == 0, c % 8 == 0);
    endtask

    task automatic t_stalls();
        for (int c = 0; c < 140; c++) begin
            cpu_freq_idx = 2'(c % 4);
            l2_freq_idx  = 2'((c / 3) % 4);
            step(c % 3 == 0, c % 2 == 0, c % 5 == 0);
        end
    endtask

    task automatic t_exact();
        align();
        step(1, 0, 1);
        for (int k = 0; k < 15; k++) step(1, k == 7, 0);
        step(1, 0, 0);
        // R7: 16 cycles over 16 instructions equals threshold 1.0 -> bin 1
        chk("R7 cpi on threshold", last_state[12:9], 1);
        // R7: 1 L2 access per 16 instructions equals 16/256 -> bin 0
        chk("R7 l2 on threshold", last_state[8:6], 0);
        // R3: memory strobe in the opening closing-cycle -> 16/256 -> bin 1
        chk("R3 closing-cycle event", last_state[5:4], 1);
    endtask

    task automatic t_rewrite();
        write_thr(1, 6, 4096);
        align();
        step(1, 1, 0);
        for (int k = 0; k < 16; k++) step(1, 1, 0);
        // R10: top L2 threshold now 16.0, ratio 1.0 -> bin 6
        chk("R10 rewritten table", last_state[8:6], 6);
    endtask

    task automatic t_saturate();
        write_thr(0, 9, 10240);
        align();
        step(1, 0, 0);
        for (int k = 0; k < 1100; k++) step(0, 0, 0);
        for (int k = 0; k < 15; k++) step(1, 0, 0);
        step(1, 0, 0);
        // R9: saturated cycle count 1023/16 > 40.0 -> bin 10
        chk("R9 saturated cpi", last_state[12:9], 10);
    endtask

    initial begin
        for (int k = 0; k < 10; k++) tc[k] = (k + 1) * 64;
        for (int k = 0; k < 7; k++)  tl[k] = (k + 1) * 64;
        for (int k = 0; k < 3; k++)  tm[k] = (k + 1) * 64;
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        t_steady();
        t_program();
        t_steady();
        t_stalls();
        t_exact();
        t_rewrite();
        t_saturate();
        t_stalls();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule